// File: doc/BRIEF.md
# Bus Master Request Gate

This block stands between the internal request sources of one device function and the outbound link request port. Every outbound read or write request passes through it on a valid/ready handshake. It decides in each cycle whether a new request may be accepted, and it counts the accepted requests that the link has not yet retired.

Software shuts mastering down in two phases. It sets a disable control bit, which closes the gate at once. It then polls a status bit. That bit falls to 0 only after every request accepted earlier has retired, so software knows the function is quiet. Clearing the bus master enable or entering the D3 power state also closes the gate.

A received packet that carries a poison (error-forwarding) mark is never forwarded. It also starts a sticky lockout of all further mastering, which only a reset ends, and it raises a one-cycle fault interrupt. Register (target) accesses continue to be served throughout.

Top module: `mstr_gate_top`

## Requirements
- R1: While the disable bit is 1, `req_ready` and `link_valid` are 0 in the same cycle. Retire pulses keep draining requests already accepted.
- R2: `master_en_sts` is a register. After each clock edge it is 0 exactly when, before that edge, the disable bit was 1 and the pending count was zero. Otherwise it is 1. Its reset value is 1.
- R3: A cycle with `dis_wr_en`=1 loads `dis_wr_val` into the disable bit, which takes effect from the next cycle. `rst` or `sw_rst` clears the bit, and a reset wins over a write in the same cycle.
- R4: While `bme` is 0 or `d3` is 1, `req_ready` and `link_valid` are 0 in the same cycle.
- R5: An inbound packet with `rx_valid`=1 and `rx_poison`=1 is dropped: `rx_fwd_valid` is 0. A clean packet is forwarded in the same cycle, with `rx_fwd_data` equal to `rx_data`.
- R6: From the cycle after a poisoned packet is received, `req_ready` and `link_valid` stay 0 until `rst` or `sw_rst`.
- R7: `tgt_ack` follows `tgt_req` in the same cycle, whatever the state of the lockout, the disable bit or the power state.
- R8: The pending count rises on each accepted request (`req_valid` and `req_ready` both 1) and falls on each `retire` pulse. When both happen in one cycle, the count holds. A retire while the count is zero is ignored. Either reset clears the count.
- R9: When MAX_OUT requests are pending, the gate closes until a retire arrives.
- R10: `fault_irq` is 1 for exactly one cycle, the first cycle of the lockout. A poisoned packet that arrives while the lockout is already active gives no new pulse.
- R11: When the gate is open, `link_valid` equals `req_valid`, `req_ready` equals `link_ready`, and `link_data` equals `req_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| sw_rst | input | 1 | Synchronous software reset, active high |
| req_valid | input | 1 | Internal request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_data | input | DATA_W | Request payload |
| link_valid | output | 1 | Request offered to the link |
| link_ready | input | 1 | Link can take a request |
| link_data | output | DATA_W | Payload offered to the link |
| retire | input | 1 | One outstanding request has completed |
| bme | input | 1 | Bus master enable from configuration space |
| d3 | input | 1 | Function is in D3 |
| dis_wr_en | input | 1 | Software write strobe for the disable bit |
| dis_wr_val | input | 1 | Value written to the disable bit |
| rx_valid | input | 1 | Inbound packet present |
| rx_poison | input | 1 | Inbound packet is marked poisoned |
| rx_data | input | RX_W | Inbound packet payload |
| rx_fwd_valid | output | 1 | Inbound packet forwarded |
| rx_fwd_data | output | RX_W | Forwarded payload |
| tgt_req | input | 1 | Register access request |
| tgt_ack | output | 1 | Register access served |
| master_en_sts | output | 1 | 0 once disabled and drained |
| fault_irq | output | 1 | One-cycle pulse on lockout entry |

## Verification
The bound assertions check in every cycle that no request is accepted while the disable bit, the power controls, the lockout or a full count closes the gate. They also check that poisoned packets never leave the block, that the count moves by one step at a time and never exceeds its limit, and that the interrupt is a single-cycle pulse at lockout entry. Other behaviour needs whole scenarios from the bench. This covers the exact cycle at which the status falls after the last retire, a spurious retire at zero leaving the status low, and an accept and a retire in the same cycle cancelling. It also covers the disable write being lost to a simultaneous reset, and register accesses still being served during the lockout.

// File: rtl/mstr_gate_pkg.sv
package mstr_gate_pkg;

    // Each field is one reason to keep the gate shut
    typedef struct packed {
        logic sw_dis;
        logic bme_off;
        logic in_d3;
        logic poisoned;
        logic cnt_full;
    } block_cause_t;

    typedef enum logic {
        LK_CLEAR    = 1'b0,
        LK_POISONED = 1'b1
    } lock_state_e;

    function automatic logic cause_blocks(input block_cause_t c);
        return |c;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned max_out);
        return (max_out < 1) ? 1 : $clog2(max_out + 1);
    endfunction

endpackage

// File: rtl/mg_ctrl_reg.sv
module mg_ctrl_reg
    import mstr_gate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sw_rst,
    input  logic dis_wr_en,
    input  logic dis_wr_val,
    input  logic rx_valid,
    input  logic rx_poison,
    output logic dis_bit,
    output logic lock_on,
    output logic fault_irq
);
    logic        any_rst;
    logic        poison_hit;
    lock_state_e lk_q, lk_d;

    assign any_rst    = rst | sw_rst;
    assign poison_hit = rx_valid & rx_poison;

    // Software disable bit: reset beats a write
    always_ff @(posedge clk) begin
        if (any_rst) begin
            dis_bit <= 1'b0;
        end else if (dis_wr_en) begin
            dis_bit <= dis_wr_val;
        end
    end

    always_comb begin
        lk_d = lk_q;
        unique case (lk_q)
            LK_CLEAR:    if (poison_hit) lk_d = LK_POISONED;
            LK_POISONED: lk_d = LK_POISONED;
            default:     lk_d = LK_CLEAR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (any_rst) begin
            lk_q      <= LK_CLEAR;
            fault_irq <= 1'b0;
        end else begin
            lk_q      <= lk_d;
            fault_irq <= (lk_q == LK_CLEAR) && (lk_d == LK_POISONED);
        end
    end

    assign lock_on = (lk_q == LK_POISONED);

endmodule

// File: rtl/mg_pend_cnt.sv
module mg_pend_cnt #(
    parameter int unsigned MAX_OUT = 16,
    parameter int unsigned CW      = mstr_gate_pkg::cnt_width(MAX_OUT)
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          empty,
    output logic          full
);
    localparam logic [CW-1:0] LIMIT = CW'(MAX_OUT);
    localparam logic [CW-1:0] ONE   = CW'(1);

    logic dec_eff;

    assign empty   = (cnt == '0);
    assign full    = (cnt >= LIMIT);
    // A retire with nothing pending is spurious and dropped
    assign dec_eff = dec & ~empty;

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt <= '0;
        end else begin
            unique case ({inc, dec_eff})
                2'b10:   cnt <= cnt + ONE;
                2'b01:   cnt <= cnt - ONE;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/mg_status.sv
module mg_status (
    input  logic clk,
    input  logic clr,
    input  logic dis_bit,
    input  logic empty,
    output logic master_en_sts
);
    always_ff @(posedge clk) begin
        if (clr) begin
            master_en_sts <= 1'b1;
        end else begin
            master_en_sts <= ~(dis_bit & empty);
        end
    end
endmodule

// File: rtl/mg_rx_filter.sv
module mg_rx_filter #(
    parameter int unsigned RX_W = 32
) (
    input  logic            rx_valid,
    input  logic            rx_poison,
    input  logic [RX_W-1:0] rx_data,
    output logic            rx_fwd_valid,
    output logic [RX_W-1:0] rx_fwd_data
);
    assign rx_fwd_valid = rx_valid & ~rx_poison;
    assign rx_fwd_data  = rx_data;
endmodule

// File: rtl/mstr_gate_top.sv
module mstr_gate_top
    import mstr_gate_pkg::*;
#(
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned RX_W    = 32,
    parameter int unsigned MAX_OUT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DATA_W-1:0] req_data,
    output logic              link_valid,
    input  logic              link_ready,
    output logic [DATA_W-1:0] link_data,
    input  logic              retire,
    input  logic              bme,
    input  logic              d3,
    input  logic              dis_wr_en,
    input  logic              dis_wr_val,
    input  logic              rx_valid,
    input  logic              rx_poison,
    input  logic [RX_W-1:0]   rx_data,
    output logic              rx_fwd_valid,
    output logic [RX_W-1:0]   rx_fwd_data,
    input  logic              tgt_req,
    output logic              tgt_ack,
    output logic              master_en_sts,
    output logic              fault_irq
);
    localparam int unsigned CW = cnt_width(MAX_OUT);

    logic          any_rst;
    logic          dis_bit;
    logic          lock_on;
    logic          cnt_empty;
    logic          cnt_full;
    logic [CW-1:0] cnt;
    logic          gate_open;
    logic          accept;
    block_cause_t  cause;

    assign any_rst = rst | sw_rst;

    mg_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .sw_rst     (sw_rst),
        .dis_wr_en  (dis_wr_en),
        .dis_wr_val (dis_wr_val),
        .rx_valid   (rx_valid),
        .rx_poison  (rx_poison),
        .dis_bit    (dis_bit),
        .lock_on    (lock_on),
        .fault_irq  (fault_irq)
    );

    always_comb begin
        cause          = '0;
        cause.sw_dis   = dis_bit;
        cause.bme_off  = ~bme;
        cause.in_d3    = d3;
        cause.poisoned = lock_on;
        cause.cnt_full = cnt_full;
    end

    assign gate_open  = ~cause_blocks(cause);
    assign req_ready  = gate_open & link_ready;
    assign link_valid = gate_open & req_valid;
    assign link_data  = req_data;
    assign accept     = req_valid & req_ready;

    mg_pend_cnt #(
        .MAX_OUT (MAX_OUT),
        .CW      (CW)
    ) u_cnt (
        .clk   (clk),
        .clr   (any_rst),
        .inc   (accept),
        .dec   (retire),
        .cnt   (cnt),
        .empty (cnt_empty),
        .full  (cnt_full)
    );

    mg_status u_sts (
        .clk           (clk),
        .clr           (any_rst),
        .dis_bit       (dis_bit),
        .empty         (cnt_empty),
        .master_en_sts (master_en_sts)
    );

    mg_rx_filter #(
        .RX_W (RX_W)
    ) u_rx (
        .rx_valid     (rx_valid),
        .rx_poison    (rx_poison),
        .rx_data      (rx_data),
        .rx_fwd_valid (rx_fwd_valid),
        .rx_fwd_data  (rx_fwd_data)
    );

    // Target accesses bypass every mastering control
    assign tgt_ack = tgt_req;

endmodule

// File: rtl/mstr_gate_chk.sv
module mstr_gate_chk #(
    parameter int unsigned MAX_OUT = 16,
    parameter int unsigned CW      = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          sw_rst,
    input logic          req_valid,
    input logic          req_ready,
    input logic          link_valid,
    input logic          retire,
    input logic          bme,
    input logic          d3,
    input logic          rx_valid,
    input logic          rx_poison,
    input logic          rx_fwd_valid,
    input logic          fault_irq,
    input logic          master_en_sts,
    input logic          dis_bit,
    input logic          lock_on,
    input logic [CW-1:0] cnt
);
    logic cnt_zero;
    assign cnt_zero = (cnt == '0);

    AST_DIS_BLOCKS: assert property (@(posedge clk) disable iff (rst || sw_rst)
        dis_bit |-> (!req_ready && !link_valid)); // R1

    AST_STS_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst || sw_rst)
        (dis_bit && cnt_zero) |=> !master_en_sts); // R2

    AST_STS_HIGH_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst || sw_rst)
        (!dis_bit || !cnt_zero) |=> master_en_sts); // R2

    AST_RST_CLEARS_DIS: assert property (@(posedge clk)
        (rst || sw_rst) |=> !dis_bit); // R3

    AST_POWER_BLOCKS: assert property (@(posedge clk) disable iff (rst || sw_rst)
        (!bme || d3) |-> (!req_ready && !link_valid)); // R4

    AST_POISON_DROPPED: assert property (@(posedge clk) disable iff (rst || sw_rst)
        (rx_valid && rx_poison) |-> !rx_fwd_valid); // R5

    AST_POISON_LOCKS: assert property (@(posedge clk) disable iff (rst || sw_rst)
        (rx_valid && rx_poison) |=> lock_on); // R6

    AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (rst || sw_rst)
        lock_on |-> (!req_ready && !link_valid)); // R6

    AST_CNT_UP: assert property (@(posedge clk) disable iff (rst || sw_rst)
        (req_valid && req_ready && !retire) |=> (cnt == $past(cnt) + CW'(1))); // R8

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst || sw_rst)
        (req_valid && req_ready && retire && !cnt_zero) |=> $stable(cnt)); // R8

    AST_CNT_ZERO_RETIRE: assert property (@(posedge clk) disable iff (rst || sw_rst)
        (cnt_zero && retire && !(req_valid && req_ready)) |=> cnt_zero); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst || sw_rst)
        (cnt <= CW'(MAX_OUT))); // R9

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst || sw_rst)
        (cnt == CW'(MAX_OUT)) |-> !req_ready); // R9

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst || sw_rst)
        fault_irq |=> !fault_irq); // R10

    AST_IRQ_AT_ENTRY: assert property (@(posedge clk) disable iff (rst || sw_rst)
        $rose(lock_on) |-> fault_irq); // R10

endmodule

bind mstr_gate_top mstr_gate_chk #(
    .MAX_OUT (MAX_OUT),
    .CW      (CW)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .sw_rst        (sw_rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .link_valid    (link_valid),
    .retire        (retire),
    .bme           (bme),
    .d3            (d3),
    .rx_valid      (rx_valid),
    .rx_poison     (rx_poison),
    .rx_fwd_valid  (rx_fwd_valid),
    .fault_irq     (fault_irq),
    .master_en_sts (master_en_sts),
    .dis_bit       (dis_bit),
    .lock_on       (lock_on),
    .cnt           (cnt)
);

// File: tb/mstr_gate_top_tb_top.sv
module mstr_gate_top_tb_top;
    localparam int unsigned DATA_W  = 64;
    localparam int unsigned RX_W    = 32;
    localparam int unsigned MAX_OUT = 16;

    logic              clk = 1'b0;
    logic              rst, sw_rst;
    logic              req_valid, req_ready;
    logic [DATA_W-1:0] req_data;
    logic              link_valid, link_ready;
    logic [DATA_W-1:0] link_data;
    logic              retire, bme, d3, dis_wr_en, dis_wr_val;
    logic              rx_valid, rx_poison;
    logic [RX_W-1:0]   rx_data;
    logic              rx_fwd_valid;
    logic [RX_W-1:0]   rx_fwd_data;
    logic              tgt_req, tgt_ack, master_en_sts, fault_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    mstr_gate_top #(
        .DATA_W  (DATA_W),
        .RX_W    (RX_W),
        .MAX_OUT (MAX_OUT)
    ) dut_i (
        .clk           (clk),
        .rst           (rst),
        .sw_rst        (sw_rst),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_data      (req_data),
        .link_valid    (link_valid),
        .link_ready    (link_ready),
        .link_data     (link_data),
        .retire        (retire),
        .bme           (bme),
        .d3            (d3),
        .dis_wr_en     (dis_wr_en),
        .dis_wr_val    (dis_wr_val),
        .rx_valid      (rx_valid),
        .rx_poison     (rx_poison),
        .rx_data       (rx_data),
        .rx_fwd_valid  (rx_fwd_valid),
        .rx_fwd_data   (rx_fwd_data),
        .tgt_req       (tgt_req),
        .tgt_ack       (tgt_ack),
        .master_en_sts (master_en_sts),
        .fault_irq     (fault_irq)
    );

    // Fields per row: {bme, d3, disable value, expected gate open}
    localparam logic [3:0] VEC [8] = '{
        4'b1_0_0_1, 4'b1_0_1_0, 4'b0_0_0_0, 4'b1_1_0_0,
        4'b0_1_0_0, 4'b0_0_1_0, 4'b1_1_1_0, 4'b1_0_0_1
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    task automatic wr_dis(input logic v);
        dis_wr_en  = 1'b1;
        dis_wr_val = v;
        nxt();
        dis_wr_en  = 1'b0;
    endtask

    task automatic sw_reset();
        sw_rst = 1'b1;
        nxt();
        sw_rst = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; sw_rst = 1'b0;
        req_valid = 1'b0; req_data = '0; link_ready = 1'b1; retire = 1'b0;
        bme = 1'b1; d3 = 1'b0; dis_wr_en = 1'b0; dis_wr_val = 1'b0;
        rx_valid = 1'b0; rx_poison = 1'b0; rx_data = '0; tgt_req = 1'b0;
        repeat (3) nxt();
        rst = 1'b0;

        // Reset state
        #1;
        check("R2 reset status", 64'(master_en_sts), 64'd1);
        check("R10 reset irq", 64'(fault_irq), 64'd0);
        req_valid = 1'b1; #1;
        check("R11 reset ready", 64'(req_ready), 64'd1);
        req_valid = 1'b0;
        nxt();

        // Table of gate conditions
        for (int i = 0; i < 8; i++) begin
            bme = VEC[i][3]; d3 = VEC[i][2];
            wr_dis(VEC[i][1]);
            req_valid = 1'b1; link_ready = 1'b1;
            req_data = 64'hA5A5_0000_0000_0000 | 64'(i);
            #1;
            check($sformatf("R1 R4 R11 vec%0d ready", i), 64'(req_ready), 64'(VEC[i][0]));
            check($sformatf("R1 R4 R11 vec%0d link_valid", i), 64'(link_valid), 64'(VEC[i][0]));
            if (VEC[i][0]) check($sformatf("R11 vec%0d data", i), link_data, req_data);
            nxt();
            req_valid = 1'b0; retire = 1'b1;
            nxt();
            retire = 1'b0;
        end
        bme = 1'b1; d3 = 1'b0;
        wr_dis(1'b0);
        nxt();

        // R11: link back-pressure passes through
        req_valid = 1'b1; link_ready = 1'b0; #1;
        check("R11 ready follows link", 64'(req_ready), 64'd0);
        check("R11 valid offered", 64'(link_valid), 64'd1);
        req_valid = 1'b0; link_ready = 1'b1;
        nxt();

        // Drain: three accepted, then disable
        req_valid = 1'b1;
        repeat (3) nxt();
        req_valid = 1'b0;
        wr_dis(1'b1);
        req_valid = 1'b1; #1;
        check("R1 disable blocks", 64'(req_ready), 64'd0);
        check("R2 busy status", 64'(master_en_sts), 64'd1);
        req_valid = 1'b0;
        retire = 1'b1;
        repeat (3) nxt();
        retire = 1'b0; #1;
        check("R2 status one cycle late", 64'(master_en_sts), 64'd1);
        nxt();
        check("R2 quiesced", 64'(master_en_sts), 64'd0);
        // Spurious retire at zero
        retire = 1'b1;
        nxt();
        retire = 1'b0;
        nxt();
        check("R8 retire at zero ignored", 64'(master_en_sts), 64'd0);
        wr_dis(1'b0);
        check("R2 status after clear lags", 64'(master_en_sts), 64'd0);
        nxt();
        check("R3 status restored", 64'(master_en_sts), 64'd1);

        // Accept and retire together hold the count
        req_valid = 1'b1;
        nxt();
        retire = 1'b1;
        nxt();
        req_valid = 1'b0; retire = 1'b0;
        wr_dis(1'b1);
        nxt();
        check("R8 hold keeps one pending", 64'(master_en_sts), 64'd1);
        retire = 1'b1;
        nxt();
        retire = 1'b0;
        nxt();
        check("R8 last retire drains", 64'(master_en_sts), 64'd0);

        // Reset clears disable and beats a write
        dis_wr_en = 1'b1; dis_wr_val = 1'b1;
        sw_reset();
        dis_wr_en = 1'b0;
        req_valid = 1'b1; #1;
        check("R3 sw_rst clears disable", 64'(req_ready), 64'd1);
        req_valid = 1'b0;
        nxt();
        check("R3 status after sw_rst", 64'(master_en_sts), 64'd1);

        // Fill to the limit
        req_valid = 1'b1;
        for (int k = 0; k < int'(MAX_OUT); k++) begin
            #1;
            check($sformatf("R9 accept %0d", k), 64'(req_ready), 64'd1);
            nxt();
        end
        #1;
        check("R9 full blocks", 64'(req_ready), 64'd0);
        req_valid = 1'b0; retire = 1'b1;
        nxt();
        retire = 1'b0; req_valid = 1'b1; #1;
        check("R9 retire reopens", 64'(req_ready), 64'd1);
        req_valid = 1'b0;
        sw_reset();

        // Inbound filter and poison lockout
        rx_valid = 1'b1; rx_poison = 1'b0; rx_data = 32'hCAFE_0001; #1;
        check("R5 clean forwarded", 64'(rx_fwd_valid), 64'd1);
        check("R5 clean data", 64'(rx_fwd_data), 64'hCAFE_0001);
        nxt();
        rx_poison = 1'b1; #1;
        check("R5 poison dropped", 64'(rx_fwd_valid), 64'd0);
        nxt();
        rx_valid = 1'b0; rx_poison = 1'b0;
        req_valid = 1'b1; tgt_req = 1'b1; #1;
        check("R10 irq at lock entry", 64'(fault_irq), 64'd1);
        check("R6 lock blocks", 64'(req_ready), 64'd0);
        check("R7 target served in lock", 64'(tgt_ack), 64'd1);
        nxt();
        check("R10 irq one cycle", 64'(fault_irq), 64'd0);
        check("R6 lock sticky", 64'(req_ready), 64'd0);
        rx_valid = 1'b1; rx_poison = 1'b1;
        nxt();
        rx_valid = 1'b0; rx_poison = 1'b0; #1;
        check("R10 no second irq", 64'(fault_irq), 64'd0);
        tgt_req = 1'b0; #1;
        check("R7 target idle", 64'(tgt_ack), 64'd0);
        req_valid = 1'b0;
        sw_reset();
        req_valid = 1'b1; #1;
        check("R6 reset ends lock", 64'(req_ready), 64'd1);
        req_valid = 1'b0;
        nxt();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule